// File: doc/BRIEF.md
# Sensor Telemetry Streaming Sequencer

This block lets an external policy controller, which reaches the chip only through a serial slave port, collect every thermal sensor reading with a single read command. The chip has 44 thermal sense points: five per core chiplet, plus extra points for emergency thermal protection and for the memory controllers. The block holds these readings in a sensor register file, which the sensor side updates through a write port. A programmable transaction table lists which readings go out, in what order and at what width.

When a stream request arrives and the block is idle, the sequencer walks the table from slot 0. It fetches each listed reading and packs the fields tightly into bytes, so fewer read operations are needed. The bytes leave on a valid/ready byte stream that feeds the serial slave. The consumer may stall the stream at any time by holding `out_ready` low. While stalled, the offered byte and its last marker stay frozen until they are accepted. The last byte of a stream is flagged with `out_last`.

The block also decodes multicast writes. One command carries a payload and a bitmask of targets, and every selected target register takes the payload in the same cycle. One write command therefore updates many targets.

Top module: `telem_stream_seq`

## Requirements
- R1: After reset, `out_valid` and `busy` are low and every target register reads zero.
- R2: A `rd_req` seen while `busy` is low starts a stream. The stream walks the table from slot 0 upward. It stops after the first entry whose end flag is set, or after the highest table slot, whichever comes first.
- R3: A table entry is 9 bits:
  - bits 5:0 hold the sensor index;
  - bits 7:6 hold the width code (00 = 4 bits, 01 = 8 bits, 10 or 11 = 12 bits);
  - bit 8 is the end flag.

  A field is the low width bits of the indexed reading. An index of 44 or more contributes zero bits of that width.
- R4: Fields are packed LSB-first with no gaps. The first field starts at bit 0 of the first byte. Each later field continues at the next free bit and may span byte boundaries.
- R5: If the packed bit count is not a multiple of 8, the final byte is padded with zeros in its upper bits. `out_last` is high on the final byte of a stream and on no other byte.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R7: `busy` rises in the cycle after an accepted request. It falls in the cycle after the final byte is accepted. A `rd_req` while `busy` is high is ignored and starts no further stream.
- R8: When `mc_valid` is high, every target register whose `mc_mask` bit is set takes `mc_data` one cycle later. Targets with a clear mask bit keep their values.
- R9: A sensor write through `sens_wr_*` replaces that reading from the next cycle on. Later streams carry the new value.
- R10: A table write through `tbl_wr_*` replaces that slot from the next cycle on. Later streams follow the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sens_wr_en | input | 1 | Sensor reading write strobe |
| sens_wr_idx | input | 6 | Sensor index to write |
| sens_wr_data | input | 12 | New sensor reading |
| tbl_wr_en | input | 1 | Table slot write strobe |
| tbl_wr_addr | input | 6 | Table slot to write |
| tbl_wr_data | input | 9 | Table entry (index, width code, end flag) |
| rd_req | input | 1 | Stream request |
| busy | output | 1 | A stream is in progress or its last byte is not yet accepted |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream ready from the serial slave |
| out_data | output | 8 | Streamed byte |
| out_last | output | 1 | Final byte of the stream |
| mc_valid | input | 1 | Multicast write strobe |
| mc_mask | input | 8 | One bit per target register |
| mc_data | input | 8 | Multicast payload |
| tgt_regs | output | 64 | Target registers, target n at bits 8n+7:8n |

## Verification
The timing of streamed bytes depends on field widths and on back-pressure, so the bench never assumes a fixed latency. It compares each offered byte with the front of an ordered queue of expected bytes, and pops that queue only on a cycle where valid and ready are both high. `busy` is due exactly one cycle after an accepted request and drops one cycle after the final handshake. Multicast results are due one cycle after the command. The bench samples a quarter period after the falling edge, when inputs for the coming edge are already set, and applies each modelled effect to its own state at that same sample point. Every comparison in the following cycle therefore sees the state that one rising edge produces.

// File: rtl/telem_pkg.sv
package telem_pkg;

  localparam int FIELD_MAX = 12;
  localparam int BYTE_W    = 8;

  typedef enum logic [1:0] {
    FW_NIBBLE   = 2'b00,
    FW_BYTE     = 2'b01,
    FW_WIDE     = 2'b10,
    FW_WIDE_ALT = 2'b11
  } fw_code_e;

  // Number of bits a width code selects.
  function automatic logic [4:0] fw_bits(input logic [1:0] code);
    case (fw_code_e'(code))
      FW_NIBBLE: return 5'd4;
      FW_BYTE:   return 5'd8;
      default:   return 5'd12;
    endcase
  endfunction

  // Mask keeping the low fw_bits(code) bits of a field.
  function automatic logic [FIELD_MAX-1:0] fw_mask(input logic [1:0] code);
    return {FIELD_MAX{1'b1}} >> (5'(FIELD_MAX) - fw_bits(code));
  endfunction

endpackage

// File: rtl/telem_sensor_rf.sv
module telem_sensor_rf #(
  parameter int NUM = 44,
  parameter int DW  = 12,
  parameter int IW  = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NUM - 1);

  logic [DW-1:0] mem [NUM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) mem[i] <= '0;
    end else if (wr_en && (wr_idx <= LAST_IDX)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // Indices past the last sense point read as zero.
  assign rd_data = (rd_idx <= LAST_IDX) ? mem[rd_idx] : '0;

  AST_SENS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx <= LAST_IDX)) |=> (mem[$past(wr_idx)] == $past(wr_data))); // R9

endmodule

// File: rtl/telem_xact_table.sv
module telem_xact_table #(
  parameter int DEPTH = 64,
  parameter int EW    = 9,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [EW-1:0] rd_entry
);

  logic [EW-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (wr_en) begin
      slot[wr_addr] <= wr_data;
    end
  end

  assign rd_entry = slot[rd_addr];

  AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slot[$past(wr_addr)] == $past(wr_data))); // R10

endmodule

// File: rtl/telem_mcast_bank.sv
module telem_mcast_bank #(
  parameter int NT = 8,
  parameter int TW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mc_valid,
  input  logic [NT-1:0]  mc_mask,
  input  logic [TW-1:0]  mc_data,
  output logic [NT*TW-1:0] regs_flat
);

  logic [TW-1:0] reg_q [NT];

  for (genvar g = 0; g < NT; g++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (!rst_n)                       reg_q[g] <= '0;
      else if (mc_valid && mc_mask[g])  reg_q[g] <= mc_data;
    end

    assign regs_flat[g*TW +: TW] = reg_q[g];

    AST_MC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_valid && mc_mask[g]) |=> (regs_flat[g*TW +: TW] == $past(mc_data))); // R8
    AST_MC_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !(mc_valid && mc_mask[g]) |=> $stable(regs_flat[g*TW +: TW])); // R8
  end

endmodule

// File: rtl/telem_packer.sv
module telem_packer
  import telem_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 12,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] tbl_ptr,
  input  logic [1:0]    ent_code,
  input  logic          ent_end,
  input  logic [DW-1:0] field_in,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic          out_last
);

  // Worst case: 7 leftover bits plus one widest field.
  localparam int ACC_W = BYTE_W + FIELD_MAX - 1;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);
  localparam logic [AW-1:0]    TOP_SLOT = AW'(DEPTH - 1);

  logic             run_q;
  logic             fetch_done_q;
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] obyte_q;
  logic             ovalid_q;
  logic             olast_q;

  logic [FIELD_MAX-1:0] fld;
  logic [CNT_W-1:0]     fbits;
  logic can_load, have_byte, flush, do_emit, do_fetch, emit_last, take_start;

  always_comb begin
    fld        = FIELD_MAX'(field_in) & fw_mask(ent_code);
    fbits      = CNT_W'(fw_bits(ent_code));
    can_load   = !ovalid_q || out_ready;
    have_byte  = cnt_q >= BYTE_CNT;
    flush      = fetch_done_q && (cnt_q != '0);
    do_emit    = run_q && can_load && (have_byte || flush);
    do_fetch   = run_q && !fetch_done_q && !have_byte;
    emit_last  = fetch_done_q && (cnt_q <= BYTE_CNT);
    take_start = start && !busy;
  end

  // Sequencing: table walk, bit accumulator and run control.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      fetch_done_q <= 1'b0;
      tbl_ptr      <= '0;
      acc_q        <= '0;
      cnt_q        <= '0;
    end else if (take_start) begin
      run_q        <= 1'b1;
      fetch_done_q <= 1'b0;
      tbl_ptr      <= '0;
      acc_q        <= '0;
      cnt_q        <= '0;
    end else if (do_fetch) begin
      acc_q   <= acc_q | (ACC_W'(fld) << cnt_q);
      cnt_q   <= cnt_q + fbits;
      tbl_ptr <= tbl_ptr + 1'b1;
      if (ent_end || (tbl_ptr == TOP_SLOT)) fetch_done_q <= 1'b1;
    end else if (do_emit) begin
      acc_q <= acc_q >> BYTE_W;
      cnt_q <= have_byte ? (cnt_q - BYTE_CNT) : '0;
      if (emit_last) run_q <= 1'b0;
    end
  end

  // Output register with valid/ready hold.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovalid_q <= 1'b0;
      obyte_q  <= '0;
      olast_q  <= 1'b0;
    end else if (do_emit) begin
      ovalid_q <= 1'b1;
      obyte_q  <= acc_q[BYTE_W-1:0];
      olast_q  <= emit_last;
    end else if (out_ready) begin
      ovalid_q <= 1'b0;
    end
  end

  assign busy      = run_q || ovalid_q;
  assign out_valid = ovalid_q;
  assign out_data  = obyte_q;
  assign out_last  = olast_q;

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R6
  AST_EMIT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(run_q)); // R2
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ACC_W)); // R4
  AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !busy); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run_q && (tbl_ptr != '0)) |=> (tbl_ptr != '0)); // R7

endmodule

// File: rtl/telem_stream_seq.sv
module telem_stream_seq
  import telem_pkg::*;
#(
  parameter int NUM_SENSORS = 44,
  parameter int SENS_W      = 12,
  parameter int TBL_DEPTH   = 64,
  parameter int NUM_TGT     = 8,
  parameter int TGT_W       = 8,
  parameter int IDX_W       = $clog2(NUM_SENSORS),
  parameter int PTR_W       = $clog2(TBL_DEPTH),
  parameter int ENT_W       = IDX_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sens_wr_en,
  input  logic [IDX_W-1:0]         sens_wr_idx,
  input  logic [SENS_W-1:0]        sens_wr_data,
  input  logic                     tbl_wr_en,
  input  logic [PTR_W-1:0]         tbl_wr_addr,
  input  logic [ENT_W-1:0]         tbl_wr_data,
  input  logic                     rd_req,
  output logic                     busy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [7:0]               out_data,
  output logic                     out_last,
  input  logic                     mc_valid,
  input  logic [NUM_TGT-1:0]       mc_mask,
  input  logic [TGT_W-1:0]         mc_data,
  output logic [NUM_TGT*TGT_W-1:0] tgt_regs
);

  logic [PTR_W-1:0]  tbl_ptr;
  logic [ENT_W-1:0]  entry;
  logic [SENS_W-1:0] reading;

  telem_xact_table #(.DEPTH(TBL_DEPTH), .EW(ENT_W), .AW(PTR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr_en),
    .wr_addr  (tbl_wr_addr),
    .wr_data  (tbl_wr_data),
    .rd_addr  (tbl_ptr),
    .rd_entry (entry)
  );

  telem_sensor_rf #(.NUM(NUM_SENSORS), .DW(SENS_W), .IW(IDX_W)) u_sens (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sens_wr_en),
    .wr_idx  (sens_wr_idx),
    .wr_data (sens_wr_data),
    .rd_idx  (entry[IDX_W-1:0]),
    .rd_data (reading)
  );

  telem_packer #(.DEPTH(TBL_DEPTH), .DW(SENS_W), .AW(PTR_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_req),
    .tbl_ptr   (tbl_ptr),
    .ent_code  (entry[IDX_W +: 2]),
    .ent_end   (entry[IDX_W + 2]),
    .field_in  (reading),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  telem_mcast_bank #(.NT(NUM_TGT), .TW(TGT_W)) u_mcast (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_valid  (mc_valid),
    .mc_mask   (mc_mask),
    .mc_data   (mc_data),
    .regs_flat (tgt_regs)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!busy && !out_valid && (tgt_regs == '0))); // R1

endmodule

// File: tb/telem_stream_seq_tb.sv
module telem_stream_seq_tb;

  localparam int CLK_P = 10;
  localparam int NS = 44;
  localparam int DEPTH = 64;
  localparam int NT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sens_wr_en = 1'b0;
  logic [5:0]  sens_wr_idx = '0;
  logic [11:0] sens_wr_data = '0;
  logic        tbl_wr_en = 1'b0;
  logic [5:0]  tbl_wr_addr = '0;
  logic [8:0]  tbl_wr_data = '0;
  logic        rd_req = 1'b0;
  logic        busy;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_last;
  logic        mc_valid = 1'b0;
  logic [7:0]  mc_mask = '0;
  logic [7:0]  mc_data = '0;
  logic [63:0] tgt_regs;

  telem_stream_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .sens_wr_en(sens_wr_en), .sens_wr_idx(sens_wr_idx), .sens_wr_data(sens_wr_data),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .rd_req(rd_req), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .mc_valid(mc_valid), .mc_mask(mc_mask), .mc_data(mc_data), .tgt_regs(tgt_regs)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;
  int ready_mode = 0;

  // Reference model state
  logic [11:0] m_sens [NS];
  logic [8:0]  m_tbl [DEPTH];
  logic [7:0]  m_tgt [NT];
  logic [7:0]  exp_q [$];
  bit          m_busy = 1'b0;
  bit          prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;
  bit          prev_last = 1'b0;
  int          streams_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Build the expected byte list from the model table and readings.
  task automatic push_stream();
    bit bits [$];
    for (int e = 0; e < DEPTH; e++) begin
      int idx = int'(m_tbl[e][5:0]);
      int w = (m_tbl[e][7:6] == 2'b00) ? 4 : (m_tbl[e][7:6] == 2'b01) ? 8 : 12;
      logic [11:0] v = (idx < NS) ? m_sens[idx] : 12'h000;
      for (int b = 0; b < w; b++) bits.push_back(v[b]);
      if (m_tbl[e][8] || e == DEPTH - 1) break;
    end
    while (bits.size() % 8 != 0) bits.push_back(1'b0);
    for (int k = 0; k < bits.size(); k += 8) begin
      logic [7:0] byt = '0;
      for (int b = 0; b < 8; b++) byt[b] = bits[k + b];
      exp_q.push_back(byt);
    end
  endtask

  // Per-cycle comparison, a quarter period after the falling edge.
  initial begin
    for (int i = 0; i < NS; i++) m_sens[i] = '0;
    for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
    for (int i = 0; i < NT; i++) m_tgt[i] = '0;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n) begin
        for (int t = 0; t < NT; t++)
          chk(tgt_regs[t*8 +: 8] == m_tgt[t], "R8", $sformatf("target %0d", t),
              tgt_regs[t*8 +: 8], m_tgt[t]);
        chk(busy == m_busy, "R7", "busy", busy, m_busy);
        if (prev_stall) begin
          chk(out_valid == 1'b1, "R6", "valid held", out_valid, 1);
          chk(out_data == prev_data && out_last == prev_last, "R6", "data held",
              out_data, prev_data);
        end
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected byte", out_data, 0);
          end else begin
            chk(out_data == exp_q[0], "R4", "byte value", out_data, exp_q[0]);
            chk(out_last == (exp_q.size() == 1), "R5", "last flag", out_last,
                exp_q.size() == 1);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        prev_last  = out_last;
        // Effects of the coming rising edge.
        if (out_valid && out_ready && exp_q.size() != 0) begin
          void'(exp_q.pop_front());
          if (out_last) begin
            m_busy = 1'b0;
            streams_done++;
          end
        end
        if (rd_req && !m_busy) begin
          push_stream();
          m_busy = 1'b1;
        end
        if (mc_valid)
          for (int t = 0; t < NT; t++) if (mc_mask[t]) m_tgt[t] = mc_data;
      end
    end
  end

  // Ready pattern generator
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0];
        default: out_ready = ~out_ready;
      endcase
    end
  end

  task automatic wr_sens(input int idx, input logic [11:0] val);
    @(negedge clk);
    sens_wr_en = 1'b1; sens_wr_idx = 6'(idx); sens_wr_data = val;
    if (idx < NS) m_sens[idx] = val;
    @(negedge clk);
    sens_wr_en = 1'b0;
  endtask

  task automatic wr_tbl(input int addr, input int idx, input int code, input bit endf);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = 6'(addr);
    tbl_wr_data = {endf, 2'(code), 6'(idx)};
    m_tbl[addr] = {endf, 2'(code), 6'(idx)};
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic mcast(input logic [7:0] mask, input logic [7:0] data);
    @(negedge clk);
    mc_valid = 1'b1; mc_mask = mask; mc_data = data;
    @(negedge clk);
    mc_valid = 1'b0;
  endtask

  task automatic wait_stream(input int expect_done);
    forever begin
      @(negedge clk);
      #(CLK_P/2);
      if (!m_busy && exp_q.size() == 0 && !busy) break;
    end
    chk(streams_done == expect_done, "R2", "stream count", streams_done, expect_done);
    chk(out_valid == 1'b0, "R7", "quiet after stream", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/4);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(tgt_regs == '0, "R1", "targets after reset", tgt_regs, 0);

    // R9: load readings
    for (int i = 0; i < NS; i++) wr_sens(i, 12'((i * 37 + 5) & 12'hFFF));

    // Table A: mixed widths, exact byte multiple; multicast during stream (R3, R8)
    wr_tbl(0, 3, 0, 0);
    wr_tbl(1, 10, 2, 0);
    wr_tbl(2, 20, 1, 0);
    wr_tbl(3, 43, 2, 0);
    wr_tbl(4, 7, 0, 1);
    ready_mode = 0;
    pulse_req();
    mcast(8'b1010_0101, 8'h3C);
    mcast(8'h00, 8'hFF);
    mcast(8'hFF, 8'h81);
    mcast(8'b0000_0110, 8'h42);
    wait_stream(1);

    // Table B: code 11, index out of range, padded tail; ignored request (R5, R7)
    wr_tbl(0, 1, 3, 0);
    wr_tbl(1, 50, 2, 0);
    wr_tbl(2, 5, 0, 1);
    ready_mode = 1;
    pulse_req();
    repeat (3) @(negedge clk);
    pulse_req();
    wait_stream(2);

    // Single nibble entry: one padded last byte (R5)
    wr_tbl(0, 9, 0, 1);
    ready_mode = 2;
    pulse_req();
    wait_stream(3);

    // R9/R10: new reading and new table contents show up in the next stream
    wr_sens(3, 12'hABC);
    wr_tbl(0, 3, 2, 0);
    wr_tbl(1, 3, 1, 1);
    ready_mode = 1;
    pulse_req();
    wait_stream(4);

    // Full table without end flag: stops at highest slot (R2)
    for (int a = 0; a < DEPTH; a++) wr_tbl(a, a, 0, 0);
    ready_mode = 2;
    pulse_req();
    wait_stream(5);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule